// File: doc/BRIEF.md
# Indexed-Access Prioritized Interrupt Controller

This block collects up to 64 raw interrupt inputs and reduces them to one host interrupt line. Each input is first qualified by a per-source sense setting: level or edge, and active-high/rising or active-low/falling. Edge sources capture a sticky status bit on their chosen transition. Level sources report status for as long as the input sits at its active level. A per-source enable gates the status into the pending set.

Software drives the block over a plain 32-bit register bus. Single-bit changes are made by writing a source number to an index register: one register sets an enable, one clears it, and one clears a latched status. Word-wide clear registers handle bulk clean-up. A channel map assigns each source an 8-bit channel. A prioritized-index register returns the winning source, or a "none pending" flag in bit 31. The host line is raised only when the global enable bit is on and host line 0 is enabled.

Top module: `pic_idx`

## Requirements
- R1: After reset, the host line is low and every configuration word reads 0. This covers global enable, polarity, type and channel map. The prioritized-index register reads 32'h8000_0000.
- R2: Writing source number n to 0x28 enables source n, and writing n to 0x2C disables it. A written value of NUM_SRC or more changes no enable.
- R3: Writing source number n to 0x24 clears the latched status of edge source n. The write has no effect on a level source whose input is still active.
- R4: Writing a word to 0x380+4w clears the enable of source 32w+b for every set bit b. Writing a word to 0x280+4w clears the latched status of those sources in the same way.
- R5: Polarity words at 0xD00+4w and type words at 0xD80+4w hold one bit per source, with source 32w+b at bit b. Both are readable. Polarity 1 selects active-high or rising, and type 1 selects edge.
- R6: An edge source latches status on its selected transition, judged against the input sampled one clock earlier. The status stays set after the input returns, and the opposite transition latches nothing.
- R7: A level source is pending exactly while its input is at the active level and the source is enabled.
- R8: Channel map word 0x400+4w holds the channel of source 4w+k in byte k, and the word is readable. Among pending sources the lowest channel wins, and a tie goes to the lowest source number.
- R9: Reading 0x80 returns the winning source number in bits [9:0] with bit 31 clear. When nothing enabled is pending, it returns bit 31 set and the other bits 0.
- R10: The host line rises one clock after these three conditions hold together: global enable (bit 0 at 0x10) is 1, host line 0 is enabled, and a source is pending. Host line 0 is enabled by writing 0 to 0x34 and disabled by writing 0 to 0x38. Any other value written to those two registers is ignored.
- R11: The control words at 0x04 and 0x0C read 0 whatever is written to them, so only the plain non-nesting mode exists. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 13 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from state |
| irq_in | input | NUM_SRC | Raw interrupt inputs |
| host_irq | output | 1 | Host interrupt request |

## Verification
The bench enables out-of-range index values whose low bits name a live source. A decoder that truncates the index would then enable or disable the wrong source. It checks that an index status clear leaves an active level source pending, and that a rising-only edge source ignores a falling transition. Either mistake would make a source vanish or appear in the prioritized index. Channel ties, and a later lower channel on a higher source number, expose an arbiter that scans in the wrong direction or compares with the wrong strictness. Host-enable writes of a nonzero line number catch a design that tests only bit 0 or any nonzero value.

// File: rtl/pic_idx_pkg.sv
package pic_idx_pkg;
    localparam int CHAN_W    = 8;
    localparam int PRI_IDX_W = 10;
    localparam int WORD_W    = 32;

    localparam logic [12:0] A_CTRL     = 13'h004;
    localparam logic [12:0] A_HOSTCTRL = 13'h00C;
    localparam logic [12:0] A_GLB      = 13'h010;
    localparam logic [12:0] A_STCLR_IX = 13'h024;
    localparam logic [12:0] A_ENSET_IX = 13'h028;
    localparam logic [12:0] A_ENCLR_IX = 13'h02C;
    localparam logic [12:0] A_HSET_IX  = 13'h034;
    localparam logic [12:0] A_HCLR_IX  = 13'h038;
    localparam logic [12:0] A_PRI      = 13'h080;
    localparam int          B_STCLR    = 'h280;
    localparam int          B_ENCLR    = 'h380;
    localparam int          B_CHAN     = 'h400;
    localparam int          B_POL      = 'hD00;
    localparam int          B_TYP      = 'hD80;
endpackage

// File: rtl/pic_idx_cond.sv
module pic_idx_cond #(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] raw_q,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] typ,
    input  logic [NUM_SRC-1:0] latch_q,
    output logic [NUM_SRC-1:0] edge_hit,
    output logic [NUM_SRC-1:0] status
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic rise, fall;
        assign rise        = raw[i] & ~raw_q[i];
        assign fall        = ~raw[i] & raw_q[i];
        assign edge_hit[i] = typ[i] & (pol[i] ? rise : fall);
        assign status[i]   = typ[i] ? latch_q[i] : (raw[i] == pol[i]);
    end
endmodule

// File: rtl/pic_idx_arb.sv
module pic_idx_arb #(
    parameter int NUM_SRC = 64,
    parameter int CHAN_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0][CHAN_W-1:0] chan,
    output logic                           found,
    output logic [IDX_W-1:0]               win
);
    logic [CHAN_W-1:0] best;

    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '1;
        // scan downward with <= so the lowest index wins a channel tie
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && (!found || chan[i] <= best)) begin
                found = 1'b1;
                win   = IDX_W'(i);
                best  = chan[i];
            end
        end
    end
endmodule

// File: rtl/pic_idx.sv
module pic_idx
    import pic_idx_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int NWORD  = NUM_SRC / WORD_W,
    localparam int NCWORD = NUM_SRC / 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [12:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               host_irq
);
    typedef struct packed {
        logic                           glb;
        logic                           hen;
        logic                           irq;
        logic [NUM_SRC-1:0]             en;
        logic [NUM_SRC-1:0]             latch;
        logic [NUM_SRC-1:0]             pol;
        logic [NUM_SRC-1:0]             typ;
        logic [NUM_SRC-1:0]             raw_q;
        logic [NUM_SRC-1:0][CHAN_W-1:0] chan;
    } state_t;

    state_t q, d;

    logic [NUM_SRC-1:0] edge_hit, status, pend;
    logic               arb_found;
    logic [IDX_W-1:0]   arb_win;
    logic [12:0]        aw;
    logic               idx_ok;
    logic [IDX_W-1:0]   idx;

    pic_idx_cond #(.NUM_SRC(NUM_SRC)) u_cond (
        .raw      (irq_in),
        .raw_q    (q.raw_q),
        .pol      (q.pol),
        .typ      (q.typ),
        .latch_q  (q.latch),
        .edge_hit (edge_hit),
        .status   (status)
    );

    assign pend = status & q.en;

    pic_idx_arb #(.NUM_SRC(NUM_SRC), .CHAN_W(CHAN_W)) u_arb (
        .pend  (pend),
        .chan  (q.chan),
        .found (arb_found),
        .win   (arb_win)
    );

    assign aw     = {bus_addr[12:2], 2'b00};
    assign idx_ok = bus_wdata < 32'(NUM_SRC);
    assign idx    = bus_wdata[IDX_W-1:0];

    always_comb begin
        d       = q;
        d.raw_q = irq_in;
        if (bus_we) begin
            if (aw == A_GLB)                d.glb = bus_wdata[0];
            if (aw == A_HSET_IX && bus_wdata == 32'd0) d.hen = 1'b1;
            if (aw == A_HCLR_IX && bus_wdata == 32'd0) d.hen = 1'b0;
            if (aw == A_ENSET_IX && idx_ok) d.en[idx]    = 1'b1;
            if (aw == A_ENCLR_IX && idx_ok) d.en[idx]    = 1'b0;
            if (aw == A_STCLR_IX && idx_ok) d.latch[idx] = 1'b0;
            for (int w = 0; w < NWORD; w++) begin
                if (int'(aw) == B_STCLR + 4 * w) d.latch[w*WORD_W +: WORD_W] &= ~bus_wdata;
                if (int'(aw) == B_ENCLR + 4 * w) d.en[w*WORD_W +: WORD_W]    &= ~bus_wdata;
                if (int'(aw) == B_POL + 4 * w)   d.pol[w*WORD_W +: WORD_W]   = bus_wdata;
                if (int'(aw) == B_TYP + 4 * w)   d.typ[w*WORD_W +: WORD_W]   = bus_wdata;
            end
            for (int w = 0; w < NCWORD; w++) begin
                if (int'(aw) == B_CHAN + 4 * w) begin
                    for (int k = 0; k < 4; k++) d.chan[4*w+k] = bus_wdata[8*k +: 8];
                end
            end
        end
        // a new edge beats a clear in the same cycle; level sources keep no latch
        d.latch = (d.latch | edge_hit) & q.typ;
        d.irq   = q.glb & q.hen & (|pend);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aw == A_GLB) bus_rdata = {31'd0, q.glb};
        if (aw == A_PRI) bus_rdata = arb_found ? {22'd0, PRI_IDX_W'(arb_win)} : 32'h8000_0000;
        for (int w = 0; w < NWORD; w++) begin
            if (int'(aw) == B_POL + 4 * w) bus_rdata = q.pol[w*WORD_W +: WORD_W];
            if (int'(aw) == B_TYP + 4 * w) bus_rdata = q.typ[w*WORD_W +: WORD_W];
        end
        for (int w = 0; w < NCWORD; w++) begin
            if (int'(aw) == B_CHAN + 4 * w)
                bus_rdata = {q.chan[4*w+3], q.chan[4*w+2], q.chan[4*w+1], q.chan[4*w]};
        end
    end

    assign host_irq = q.irq;
endmodule

// File: rtl/pic_idx_chk.sv
module pic_idx_chk #(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_irq,
    input logic               glb,
    input logic               hen,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] edge_hit,
    input logic [NUM_SRC-1:0] latch,
    input logic               arb_found,
    input logic [IDX_W-1:0]   arb_win
);
    p_irq_needs_glb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(glb));
    p_irq_needs_hen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(hen));
    p_irq_needs_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(|pend));
    p_none_means_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_found |-> (pend == '0));
    p_winner_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_found |-> pend[arb_win]);
    p_edge_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_hit) & ~latch) == '0);
endmodule

bind pic_idx pic_idx_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_irq  (host_irq),
    .glb       (q.glb),
    .hen       (q.hen),
    .pend      (pend),
    .edge_hit  (edge_hit),
    .latch     (q.latch),
    .arb_found (arb_found),
    .arb_win   (arb_win)
);

// File: tb/pic_idx_test.sv
module pic_idx_test;
    localparam int N = 64;
    localparam logic [31:0] NONE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        host_irq;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pic_idx #(.NUM_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .host_irq(host_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cleanup();
        wr(13'h380, 32'hFFFF_FFFF);
        wr(13'h384, 32'hFFFF_FFFF);
        @(negedge clk);
        irq_in = '0;
        settle(2);
        wr(13'h280, 32'hFFFF_FFFF);
        wr(13'h284, 32'hFFFF_FFFF);
        wr(13'hD80, 32'h0);
        wr(13'hD84, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 host_irq", {31'd0, host_irq}, 32'd0);
        rd(13'h080, v); chk("R1 pri index", v, NONE);
        rd(13'h010, v); chk("R1 global", v, 32'd0);
        rd(13'hD00, v); chk("R1 polarity", v, 32'd0);
        rd(13'hD84, v); chk("R1 type", v, 32'd0);
        rd(13'h43C, v); chk("R1 chan map", v, 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(13'hD00, 32'hFFFF_FFFF);
        wr(13'hD04, 32'hFFFF_FFFF);
        rd(13'hD04, v); chk("R5 pol readback", v, 32'hFFFF_FFFF);
        wr(13'h028, 32'd5);
        rd(13'h080, v); chk("R7 inactive level", v, NONE);
        @(negedge clk); irq_in[5] = 1'b1;
        rd(13'h080, v); chk("R9/R7 active level", v, 32'd5);
        wr(13'h010, 32'd1);
        wr(13'h034, 32'd0);
        settle(2);
        chk("R10 host raised", {31'd0, host_irq}, 32'd1);
        wr(13'h024, 32'd5);
        rd(13'h080, v); chk("R3 level ignores clear", v, 32'd5);
        wr(13'h038, 32'd1);
        settle(2);
        chk("R10 nonzero line ignored", {31'd0, host_irq}, 32'd1);
        wr(13'h038, 32'd0);
        settle(2);
        chk("R10 host disabled", {31'd0, host_irq}, 32'd0);
        wr(13'h034, 32'd0);
        wr(13'h010, 32'd0);
        settle(2);
        chk("R10 global off", {31'd0, host_irq}, 32'd0);
        wr(13'h010, 32'd1);
        settle(2);
        chk("R10 global back on", {31'd0, host_irq}, 32'd1);
        @(negedge clk); irq_in[5] = 1'b0;
        rd(13'h080, v); chk("R7 level dropped", v, NONE);
        settle(2);
        chk("R10 host follows pend", {31'd0, host_irq}, 32'd0);
        cleanup();
    endtask

    task automatic t_index_range();
        logic [31:0] v;
        @(negedge clk); irq_in[5] = 1'b1;
        wr(13'h028, 32'd69);
        rd(13'h080, v); chk("R2 out-of-range set ignored", v, NONE);
        wr(13'h028, 32'd5);
        wr(13'h02C, 32'd69);
        rd(13'h080, v); chk("R2 out-of-range clear ignored", v, 32'd5);
        wr(13'h02C, 32'd5);
        rd(13'h080, v); chk("R2 index clear", v, NONE);
        cleanup();
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(13'hD80, 32'h0000_0200);
        rd(13'hD80, v); chk("R5 type readback", v, 32'h0000_0200);
        wr(13'h028, 32'd9);
        @(negedge clk); irq_in[9] = 1'b1;
        @(negedge clk); irq_in[9] = 1'b0;
        settle(1);
        rd(13'h080, v); chk("R6 rising latched", v, 32'd9);
        wr(13'h024, 32'd9);
        rd(13'h080, v); chk("R3 edge index clear", v, NONE);
        wr(13'hD00, 32'hFFFF_FDFF);
        @(negedge clk); irq_in[9] = 1'b1;
        settle(2);
        rd(13'h080, v); chk("R6 rising ignored when falling", v, NONE);
        @(negedge clk); irq_in[9] = 1'b0;
        settle(2);
        rd(13'h080, v); chk("R6 falling latched", v, 32'd9);
        wr(13'hD00, 32'hFFFF_FFFF);
        cleanup();
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(13'h400, 32'h0500_0000);
        wr(13'h428, 32'h0000_0002);
        wr(13'h43C, 32'h0002_0000);
        wr(13'h028, 32'd3);
        wr(13'h028, 32'd40);
        wr(13'h028, 32'd62);
        @(negedge clk); irq_in[3] = 1'b1; irq_in[40] = 1'b1; irq_in[62] = 1'b1;
        rd(13'h080, v); chk("R8 tie lower source", v, 32'd40);
        wr(13'h43C, 32'h0001_0000);
        rd(13'h43C, v); chk("R8 chan readback", v, 32'h0001_0000);
        rd(13'h080, v); chk("R8 lower channel wins", v, 32'd62);
        wr(13'h384, 32'h4000_0000);
        rd(13'h080, v); chk("R4 bulk enable clear bit30", v, 32'd40);
        wr(13'h384, 32'h0000_0100);
        rd(13'h080, v); chk("R4 bulk enable clear bit8", v, 32'd3);
        wr(13'h400, 32'h0);
        wr(13'h428, 32'h0);
        wr(13'h43C, 32'h0);
        cleanup();
    endtask

    task automatic t_bulk_status();
        logic [31:0] v;
        wr(13'hD84, 32'h0000_0006);
        wr(13'h028, 32'd33);
        wr(13'h028, 32'd34);
        @(negedge clk); irq_in[33] = 1'b1; irq_in[34] = 1'b1;
        @(negedge clk); irq_in[33] = 1'b0; irq_in[34] = 1'b0;
        settle(1);
        rd(13'h080, v); chk("R6 two edges lower first", v, 32'd33);
        wr(13'h284, 32'h0000_0002);
        rd(13'h080, v); chk("R4 bulk status clear bit1", v, 32'd34);
        wr(13'h284, 32'h0000_0004);
        rd(13'h080, v); chk("R4 bulk status clear bit2", v, NONE);
        cleanup();
    endtask

    task automatic t_misc();
        logic [31:0] v;
        wr(13'h004, 32'hFFFF_FFFF);
        rd(13'h004, v); chk("R11 control reads 0", v, 32'd0);
        wr(13'h00C, 32'h0000_00FF);
        rd(13'h00C, v); chk("R11 host control reads 0", v, 32'd0);
        rd(13'h300, v); chk("R11 unmapped reads 0", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_level();
        t_index_range();
        t_edge();
        t_priority();
        t_bulk_status();
        t_misc();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule